// File: doc/BRIEF.md
# Sliding-Window Sum of Absolute Differences Unit

This block is a two-stage pipelined datapath for block-matching motion search. Each operation takes two 128-bit operands of sixteen unsigned bytes each and a 3-bit selector. One operand supplies the search window and the other supplies the reference row. The selector picks a 4-byte reference group and the base of an 11-byte window. The unit slides the reference group across the window one byte at a time and returns eight sums of absolute differences, one per 16-bit lane, in a single result.

An accumulate flag adds the new sums to a caller-supplied vector of eight 16-bit words. The addition saturates, so larger blocks can be built up by repeating the operation over several rows and groups. Both sides use a valid/ready handshake. The pipeline stalls as a whole when the consumer holds off.

Top module: `msad_unit`

## Requirements
- R1: While reset is held low and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Byte i of an operand occupies bits 8i+7:8i, and lane k of `result` occupies bits 16k+15:16k. With the window base w = 4·`sel[2]` and the reference base g = 4·`sel[1:0]`, lane k (k = 0..7) equals the sum over j = 0..3 of |`win_op` byte (w+k+j) − `ref_op` byte (g+j)|.
- R3: When `acc_en` is 0, each lane holds its sum zero-extended to 16 bits, so no lane exceeds 1020.
- R4: When `acc_en` is 1, lane k equals min(`acc_in` lane k + sum k, 0xFFFF). The lane saturates and does not wrap.
- R5: With `out_ready` held high, an operation accepted at a clock edge raises `out_valid` two edges later and not one edge later.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `result` stays unchanged on the next edge.
- R7: Under any pattern of backpressure, each accepted operation yields exactly one result, in acceptance order, with no loss and no duplicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted at this edge when also valid |
| win_op | input | 128 | Sixteen window bytes |
| ref_op | input | 128 | Sixteen reference bytes |
| sel | input | 3 | [2] window base, [1:0] reference group |
| acc_en | input | 1 | Add to `acc_in` with saturation |
| acc_in | input | 128 | Eight 16-bit prior sums |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result at this edge |
| result | output | 128 | Eight 16-bit sums |

## Verification
A wrong byte offset in the window or group selection makes the affected lanes differ from the reference sums on the first result that uses that selector value. The bench therefore runs all eight selector values, both directed and at random. A wrong valid or stall register shows up within two edges as a missing, duplicated or reordered result in the expected-value queue, or as a result that changes while the consumer holds off. A saturation fault shows up only when the accumulator input is near the top of its range, so such values are forced both directed and at random.

// File: rtl/msad_unit.sv
module msad_unit #(
  parameter int BW     = 8,
  parameter int NBYTES = 16,
  parameter int GRP    = 4,
  parameter int LANES  = 8,
  parameter int RW     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NBYTES*BW-1:0]    win_op,
  input  logic [NBYTES*BW-1:0]    ref_op,
  input  logic [2:0]              sel,
  input  logic                    acc_en,
  input  logic [LANES*RW-1:0]     acc_in,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*RW-1:0]     result
);
  localparam int SADW = BW + $clog2(GRP);
  localparam int RESW = LANES * RW;
  localparam int SADMAX = GRP * ((1 << BW) - 1);

  logic             v1, v2, acc1, acc2;
  logic [RESW-1:0]  accv1, res2;
  logic [SADW-1:0]  sad_c [LANES];
  logic [SADW-1:0]  sad1  [LANES];
  logic             ld2;
  int               wbase, gbase;

  assign ld2      = !v2 || out_ready;
  assign in_ready = !v1 || ld2;
  assign out_valid = v2;
  assign result    = res2;
  assign wbase = sel[2] ? GRP : 0;
  assign gbase = int'(sel[1:0]) * GRP;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      logic [BW-1:0] a, b;
      sad_c[k] = '0;
      for (int j = 0; j < GRP; j++) begin
        a = win_op[(wbase + k + j)*BW +: BW];
        b = ref_op[(gbase + j)*BW +: BW];
        sad_c[k] = sad_c[k] + SADW'((a > b) ? (a - b) : (b - a));
      end
    end

    logic [RW:0] sum;
    assign sum = {1'b0, accv1[k*RW +: RW]} + (RW+1)'(sad1[k]);

    always_ff @(posedge clk) begin
      if (in_ready) sad1[k] <= sad_c[k];
      if (ld2 && v1)
        res2[k*RW +: RW] <= !acc1 ? RW'(sad1[k]) : (sum[RW] ? {RW{1'b1}} : sum[RW-1:0]);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (v2 && !acc2) |-> (res2[k*RW +: RW] <= RW'(SADMAX))); // R3
    AST_SAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (ld2 && v1 && acc1) |=> (res2[k*RW +: RW] >= $past(accv1[k*RW +: RW]))); // R4
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      if (in_ready) v1 <= in_valid;
      if (ld2)      v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready) begin
      acc1  <= acc_en;
      accv1 <= acc_in;
    end
    if (ld2 && v1) acc2 <= acc1;
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result))); // R6
  AST_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> v1); // R5
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && ld2) |=> out_valid); // R7
  AST_RESET: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready)); // R1
endmodule

// File: tb/msad_unit_test.sv
module msad_unit_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, acc_en = 0, out_ready = 0;
  logic [127:0] win_op = '0, ref_op = '0, acc_in = '0;
  logic [2:0] sel = '0;
  logic in_ready, out_valid;
  logic [127:0] result;

  int checks = 0, fails = 0;
  logic [127:0] exp_q[$];
  string tag_q[$];
  bit hold_pend = 0;
  logic [127:0] held;
  bit ov_seen, acc_ok;

  always #2.5 clk = ~clk;

  msad_unit uut (.clk, .rst_n, .in_valid, .in_ready, .win_op, .ref_op, .sel,
                 .acc_en, .acc_in, .out_valid, .out_ready, .result);

  function automatic logic [127:0] model(input logic [127:0] w, r, input logic [2:0] s,
                                         input bit a, input logic [127:0] ai);
    logic [127:0] o;
    int wb = s[2] * 4, gb = s[1:0] * 4;
    for (int k = 0; k < 8; k++) begin
      int sum = 0, t;
      for (int j = 0; j < 4; j++) begin
        int x = w[(wb+k+j)*8 +: 8], y = r[(gb+j)*8 +: 8];
        sum += (x > y) ? x - y : y - x;
      end
      t = a ? sum + int'(ai[k*16 +: 16]) : sum;
      o[k*16 +: 16] = (t > 65535) ? 16'hFFFF : t[15:0];
    end
    return o;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [127:0] w, r, input logic [2:0] s,
                     input bit a, input logic [127:0] ai, input bit ordy, input string tag);
    @(negedge clk);
    ov_seen = out_valid;
    if (hold_pend) begin
      check(out_valid && result == held, "R6", result, held);
      hold_pend = 0;
    end
    in_valid = v; win_op = w; ref_op = r; sel = s; acc_en = a; acc_in = ai; out_ready = ordy;
    #1;
    acc_ok = in_valid && in_ready;
    if (acc_ok) begin
      exp_q.push_back(model(w, r, s, a, ai));
      tag_q.push_back(tag);
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R7", result, '0);
      else begin
        logic [127:0] e = exp_q.pop_front();
        string t = tag_q.pop_front();
        check(result == e, t, result, e);
      end
    end
    if (out_valid && !out_ready) begin
      hold_pend = 1; held = result;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, 0, '0, 1, "R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] w, r, ai;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R1", {126'b0, out_valid, in_ready}, 128'b1);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1", {126'b0, out_valid, in_ready}, 128'b1);

    // R5 latency
    w = {$urandom, $urandom, $urandom, $urandom};
    r = {$urandom, $urandom, $urandom, $urandom};
    cyc(1, w, r, 3'd5, 0, '0, 1, "R5");
    cyc(0, '0, '0, 0, 0, '0, 1, "R5");
    check(!ov_seen, "R5", {127'b0, ov_seen}, 128'b0);
    cyc(0, '0, '0, 0, 0, '0, 1, "R5");
    check(ov_seen, "R5", {127'b0, ov_seen}, 128'b1);
    idle(2);

    // R2 every selector, directed ramp operands
    for (int i = 0; i < 16; i++) begin
      w[i*8 +: 8] = 8'(i * 17 + 3);
      r[i*8 +: 8] = 8'(255 - i * 11);
    end
    for (int s = 0; s < 8; s++) cyc(1, w, r, 3'(s), 0, '0, 1, "R2");
    idle(3);

    // R3 maximum difference
    cyc(1, {16{8'hFF}}, '0, 3'd7, 0, '0, 1, "R3");
    cyc(1, '0, {16{8'hFF}}, 3'd0, 0, '1, 1, "R3");
    idle(3);

    // R4 saturation and exact sum just below the limit
    cyc(1, {16{8'hFF}}, '0, 3'd2, 1, {8{16'hFFF0}}, 1, "R4");
    cyc(1, {16{8'hFF}}, '0, 3'd4, 1, {8{16'd64515}}, 1, "R4");
    cyc(1, w, r, 3'd6, 1, {8{16'h1234}}, 1, "R4");
    idle(3);

    // R6 stall then drain
    cyc(1, w, r, 3'd1, 0, '0, 0, "R6");
    cyc(1, r, w, 3'd3, 1, {8{16'hFF00}}, 0, "R6");
    idle(0);
    for (int i = 0; i < 3; i++) cyc(0, '0, '0, 0, 0, '0, 0, "R6");
    idle(4);

    // R7 random with backpressure
    for (int n = 0; n < 600; n++) begin
      logic [2:0] s = 3'($urandom);
      bit a = $urandom_range(0, 1);
      w = {$urandom, $urandom, $urandom, $urandom};
      r = {$urandom, $urandom, $urandom, $urandom};
      for (int k = 0; k < 8; k++)
        ai[k*16 +: 16] = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(64500, 65535)) : 16'($urandom);
      acc_ok = 0;
      while (!acc_ok) cyc(1, w, r, s, a, ai, $urandom_range(0, 9) < 7, a ? "R4/R7" : "R2/R7");
    end
    while (exp_q.size() != 0) cyc(0, '0, '0, 0, 0, '0, 1, "R7");
    idle(2);
    check(exp_q.size() == 0 && !out_valid, "R7", {127'b0, out_valid}, 128'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule